// File: doc/BRIEF.md
# Edge Timestamp Capture Timer

This block is a free-running 24-bit timer that stamps the arrival time of edges on an external input. The count limit is formed from a 16-bit interval value and an 8-bit prescale value placed above it. The timer counts system clocks either downward from that limit or upward towards it, and wraps around at the end of each interval. Whenever the chosen kind of edge appears on the input, the current count is copied into a capture register and an event status bit is raised. The timer keeps counting through every capture.

Software controls the block through a small single-cycle register port. It selects enable, direction, edge kind and load timing, writes the interval and prescale values, masks the interrupt and clears the event. The capture value, the status and the live count can all be read back. A new interval value can take effect on the cycle after it is written, restarting the interval. It can instead be held back until the current interval wraps.

Top module: `edge_stamp_timer`

## Requirements
- R1: On a qualifying edge detected in a cycle, the capture register (address 6, bits 23:0) takes the count value held during that cycle. The input passes through two synchroniser flops, so an input change is acted on at the third rising clock edge after it.
- R2: With the timer enabled and bit 1 of the control register (address 0) clear, the count decreases by one per clock. When it reaches zero it reloads the 24-bit value {prescale (address 2, bits 7:0), interval (address 1, bits 15:0)}.
- R3: With control bit 1 set, the count increases by one per clock. Once it reaches or exceeds the active limit it returns to zero.
- R4: Control bits 3:2 select the edge kind: 0 rising, 1 falling, 2 or 3 both. An edge of a kind that is not selected leaves the status and capture unchanged.
- R5: The count keeps moving after a capture. A later qualifying edge overwrites the capture register even if the status has not been cleared.
- R6: A qualifying edge sets status bit 0 (address 4). Writing 1 to bit 0 of address 5 clears it, and an edge in the same cycle as the clear wins. irq equals status AND mask (address 3, bit 0).
- R7: With control bit 4 clear, a write to address 1 or 2 while the timer runs restarts the interval in the next cycle. The count goes to the new limit when counting down and to zero when counting up.
- R8: With control bit 4 set, such a write changes only the programmed value. The active limit takes the new value at the next wrap.
- R9: Setting enable (control bit 0) while it is clear loads the start value: zero when counting up, otherwise the programmed limit. While the timer is disabled the count holds and no edges are captured.
- R10: After reset all registers, the count, the capture value, reg_rdata and irq are zero.
- R11: reg_rdata is registered. It returns, one cycle after the address is presented, the value that register held at that clock edge. Address 5 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| capt_in | input | 1 | Asynchronous input whose edges are timestamped |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked capture-event interrupt |

## Verification
The hardest case to reach from the ports is an edge and a status clear landing on the same clock. The synchroniser hides the moment of detection, so the port gives no direct view of it. The bench changes the input at a falling clock edge, waits out exactly two rising edges, and then issues the clear write so that it is sampled on the edge where the synchronised edge acts. A cycle-by-cycle model also compares every read and the interrupt line while the interval is reloaded in both load modes, both directions and across a prescaled limit.

// File: rtl/est_pkg.sv
`timescale 1ns/1ps
package est_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_LOAD  = 1;
  localparam int unsigned ADR_PRE   = 2;
  localparam int unsigned ADR_MASK  = 3;
  localparam int unsigned ADR_STAT  = 4;
  localparam int unsigned ADR_CLEAR = 5;
  localparam int unsigned ADR_CAPT  = 6;
  localparam int unsigned ADR_COUNT = 7;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_UP    = 1;
  localparam int unsigned CB_SEL   = 2;
  localparam int unsigned CB_DEFER = 4;

endpackage

// File: rtl/est_edge_detect.sv
`timescale 1ns/1ps
module est_edge_detect
  import est_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  logic      arm,
  input  edge_sel_e sel,
  output logic      hit
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              now_lvl;
  logic              rise;
  logic              fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign now_lvl = sync_q[STAGES-1];
  assign rise    = now_lvl & ~last_q;
  assign fall    = ~now_lvl & last_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = arm & rise;
      EDGE_FALL: hit = arm & fall;
      default:   hit = arm & (rise | fall);
    endcase
  end

endmodule

// File: rtl/est_counter.sv
`timescale 1ns/1ps
module est_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             up,
  input  logic             start,
  input  logic             start_up,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic [CNT_W-1:0] prog,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (start) begin
      cnt_q <= start_up ? '0 : prog;
      act_q <= prog;
    end else if (run) begin
      if (restart) begin
        cnt_q <= up ? '0 : restart_val;
        act_q <= restart_val;
      end else if (up) begin
        if (cnt_q >= act_q) begin
          cnt_q <= '0;
          act_q <= prog;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= prog;
          act_q <= prog;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/est_capture.sv
`timescale 1ns/1ps
module est_capture #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  input  logic             clr,
  input  logic             mask,
  output logic [CNT_W-1:0] cap,
  output logic             sts,
  output logic             irq
);

  logic [CNT_W-1:0] cap_q;
  logic             sts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      sts_q <= 1'b0;
    end else if (hit) begin
      cap_q <= cnt;
      sts_q <= 1'b1;
    end else if (clr) begin
      sts_q <= 1'b0;
    end
  end

  assign cap = cap_q;
  assign sts = sts_q;
  assign irq = sts_q & mask;

endmodule

// File: rtl/edge_stamp_timer.sv
`timescale 1ns/1ps
module edge_stamp_timer
  import est_pkg::*;
#(
  parameter int LOAD_W      = 16,
  parameter int PRE_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              capt_in,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int CNT_W = LOAD_W + PRE_W;

  logic              en_q;
  logic              up_q;
  logic              defer_q;
  edge_sel_e         sel_q;
  logic [LOAD_W-1:0] load_q;
  logic [PRE_W-1:0]  pre_q;
  logic              mask_q;

  logic wr_ctrl, wr_load, wr_pre, wr_mask, wr_clr;
  logic start, imm_wr, clr_wr, edge_hit, sts;
  logic [CNT_W-1:0] prog, new_prog, cnt, cap;
  logic unused_wdata;

  assign wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));
  assign wr_load = reg_we && (reg_addr == ADDR_W'(ADR_LOAD));
  assign wr_pre  = reg_we && (reg_addr == ADDR_W'(ADR_PRE));
  assign wr_mask = reg_we && (reg_addr == ADDR_W'(ADR_MASK));
  assign wr_clr  = reg_we && (reg_addr == ADDR_W'(ADR_CLEAR));

  assign prog     = {pre_q, load_q};
  assign new_prog = wr_load ? {pre_q, reg_wdata[LOAD_W-1:0]}
                            : {reg_wdata[PRE_W-1:0], load_q};
  assign start    = wr_ctrl && reg_wdata[CB_EN] && !en_q;
  assign imm_wr   = (wr_load || wr_pre) && !defer_q;
  assign clr_wr   = wr_clr && reg_wdata[0];
  assign unused_wdata = ^reg_wdata[DATA_W-1:LOAD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      up_q    <= 1'b0;
      defer_q <= 1'b0;
      sel_q   <= EDGE_RISE;
      load_q  <= '0;
      pre_q   <= '0;
      mask_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[CB_EN];
        up_q    <= reg_wdata[CB_UP];
        sel_q   <= edge_sel_e'(reg_wdata[CB_SEL+1:CB_SEL]);
        defer_q <= reg_wdata[CB_DEFER];
      end
      if (wr_load) load_q <= reg_wdata[LOAD_W-1:0];
      if (wr_pre)  pre_q  <= reg_wdata[PRE_W-1:0];
      if (wr_mask) mask_q <= reg_wdata[0];
    end
  end

  est_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk (clk),
    .rst (rst),
    .din (capt_in),
    .arm (en_q),
    .sel (sel_q),
    .hit (edge_hit)
  );

  est_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .run         (en_q),
    .up          (up_q),
    .start       (start),
    .start_up    (reg_wdata[CB_UP]),
    .restart     (imm_wr),
    .restart_val (new_prog),
    .prog        (prog),
    .cnt         (cnt)
  );

  est_capture #(.CNT_W(CNT_W)) u_cap (
    .clk  (clk),
    .rst  (rst),
    .hit  (edge_hit),
    .cnt  (cnt),
    .clr  (clr_wr),
    .mask (mask_q),
    .cap  (cap),
    .sts  (sts),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        ADDR_W'(ADR_CTRL):  reg_rdata <= DATA_W'({defer_q, sel_q, up_q, en_q});
        ADDR_W'(ADR_LOAD):  reg_rdata <= DATA_W'(load_q);
        ADDR_W'(ADR_PRE):   reg_rdata <= DATA_W'(pre_q);
        ADDR_W'(ADR_MASK):  reg_rdata <= DATA_W'(mask_q);
        ADDR_W'(ADR_STAT):  reg_rdata <= DATA_W'(sts);
        ADDR_W'(ADR_CAPT):  reg_rdata <= DATA_W'(cap);
        ADDR_W'(ADR_COUNT): reg_rdata <= DATA_W'(cnt);
        default:            reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/edge_stamp_checker.sv
`timescale 1ns/1ps
module edge_stamp_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap,
  input logic             sts,
  input logic             en,
  input logic             up,
  input logic             start,
  input logic             imm_wr,
  input logic             clr_wr
);

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
    hit |=> cap == $past(cnt)); // R1

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !up && cnt != '0 && !imm_wr) |=> cnt == $past(cnt) - 1'b1); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && up && !imm_wr) |=> (cnt == $past(cnt) + 1'b1) || (cnt == '0)); // R3

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    hit |=> sts); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !hit) |=> !sts); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !start) |=> $stable(cnt)); // R9

endmodule

bind edge_stamp_timer edge_stamp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .hit    (edge_hit),
  .cnt    (cnt),
  .cap    (cap),
  .sts    (sts),
  .en     (en_q),
  .up     (up_q),
  .start  (start),
  .imm_wr (imm_wr),
  .clr_wr (clr_wr)
);

// File: tb/tb_edge_stamp_timer.sv
`timescale 1ns/1ps
module tb_edge_stamp_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        capt_in = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  edge_stamp_timer dut (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .capt_in   (capt_in),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_en, m_up, m_sel, m_defer, m_load, m_pre, m_mask;
  int m_sts, m_cap, m_cnt, m_act, m_s1, m_s2, m_s3;
  longint m_rd;
  string m_tag = "R10";
  bit m_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_up = 0; m_sel = 0; m_defer = 0; m_load = 0; m_pre = 0; m_mask = 0;
      m_sts = 0; m_cap = 0; m_cnt = 0; m_act = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_rd = 0; m_tag = "R10"; m_live = 1'b0;
    end else begin
      int a, d, prog, np, ncnt, nact, nsts, ncap;
      bit hit, w;
      w = reg_we; a = int'(reg_addr); d = int'(reg_wdata);
      hit = (m_en != 0) && ((m_sel == 0 && m_s2 == 1 && m_s3 == 0) ||
                            (m_sel == 1 && m_s2 == 0 && m_s3 == 1) ||
                            (m_sel >= 2 && m_s2 != m_s3));
      case (a)
        0: begin m_rd = m_en + 2*m_up + 4*m_sel + 16*m_defer; m_tag = "R11"; end
        1: begin m_rd = m_load; m_tag = "R11"; end
        2: begin m_rd = m_pre; m_tag = "R11"; end
        3: begin m_rd = m_mask; m_tag = "R11"; end
        4: begin m_rd = m_sts; m_tag = "R6"; end
        6: begin m_rd = m_cap; m_tag = "R1"; end
        7: begin m_rd = m_cnt; m_tag = (m_up != 0) ? "R3" : "R2"; end
        default: begin m_rd = 0; m_tag = "R11"; end
      endcase
      prog = m_pre * 65536 + m_load;
      ncnt = m_cnt; nact = m_act;
      if (w && a == 0 && d[0] && m_en == 0) begin
        ncnt = d[1] ? 0 : prog; nact = prog;
      end else if (m_en != 0) begin
        if (w && (a == 1 || a == 2) && m_defer == 0) begin
          np = (a == 1) ? m_pre * 65536 + (d & 16'hffff) : (d & 8'hff) * 65536 + m_load;
          ncnt = (m_up != 0) ? 0 : np; nact = np;
        end else if (m_up != 0) begin
          if (m_cnt >= m_act) begin ncnt = 0; nact = prog; end
          else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin ncnt = prog; nact = prog; end
          else ncnt = m_cnt - 1;
        end
      end
      nsts = m_sts; ncap = m_cap;
      if (hit) begin ncap = m_cnt; nsts = 1; end
      else if (w && a == 5 && d[0]) nsts = 0;
      if (w && a == 0) begin
        m_en = d & 1; m_up = (d >> 1) & 1; m_sel = (d >> 2) & 3; m_defer = (d >> 4) & 1;
      end
      if (w && a == 1) m_load = d & 16'hffff;
      if (w && a == 2) m_pre = d & 8'hff;
      if (w && a == 3) m_mask = d & 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(capt_in);
      m_cnt = ncnt; m_act = nact; m_sts = nsts; m_cap = ncap;
      m_live = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk(longint'(reg_rdata) == m_rd, m_tag, longint'(reg_rdata), m_rd);
      chk(int'(irq) == (m_sts & m_mask), "R6 irq", int'(irq), m_sts & m_mask);
    end
  end

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = a[2:0];
    @(posedge clk); @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int v, c1, c2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(7, v); chk(v == 0, "R10 count", v, 0);
    rd(6, v); chk(v == 0, "R10 capture", v, 0);
    chk(irq == 1'b0, "R10 irq", int'(irq), 0);

    wr(1, 40); wr(2, 0); wr(3, 1);
    idle(5);
    rd(7, v); chk(v == 0, "R9 hold while disabled", v, 0);
    wr(0, 1);                       // enable, down, rising
    idle(20);
    rd(7, v); chk(v <= 40 && v > 0, "R2 down range", v, 40);

    capt_in = 1'b1; idle(6);
    rd(4, v); chk(v == 1, "R6 status set", v, 1);
    chk(irq == 1'b1, "R6 irq high", int'(irq), 1);
    rd(6, v); chk(v <= 40, "R1 capture in range", v, 40);
    capt_in = 1'b0; idle(6);
    wr(5, 1);
    rd(4, v); chk(v == 0, "R6 cleared", v, 0);
    idle(100);
    rd(7, v); chk(v <= 40, "R2 wrap bound", v, 40);

    wr(0, 5);                       // falling only
    capt_in = 1'b1; idle(6);
    rd(4, v); chk(v == 0, "R4 rising ignored", v, 0);
    capt_in = 1'b0; idle(6);
    rd(4, v); chk(v == 1, "R4 falling caught", v, 1);
    wr(5, 1);

    wr(0, 9);                       // both edges
    capt_in = 1'b1; idle(6);
    rd(6, c1);
    idle(10);
    capt_in = 1'b0; idle(6);
    rd(6, c2); chk(c2 != c1, "R5 capture overwritten", c2, c1);
    rd(7, c1); idle(3); rd(7, c2);
    chk(c1 != c2, "R5 keeps running", c2, c1);

    // edge and clear on the same clock
    wr(5, 1);
    capt_in = ~capt_in;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(5, 1);
    rd(4, v); chk(v == 1, "R6 edge beats clear", v, 1);
    wr(5, 1);

    wr(1, 500);                     // immediate reload
    rd(7, v); chk(v <= 500 && v > 490, "R7 immediate restart", v, 500);
    idle(30);

    wr(0, 0); wr(1, 30); wr(0, 3);  // up
    rd(7, v); chk(v < 5, "R9 up start at zero", v, 0);
    idle(100);
    rd(7, v); chk(v <= 30, "R3 up wrap bound", v, 30);

    wr(0, 0); wr(1, 200); wr(0, 19); // up, deferred
    idle(20);
    wr(1, 10);
    rd(7, v); chk(v > 15, "R8 no restart on write", v, 16);
    idle(220);
    rd(7, v); chk(v <= 10, "R8 new limit after wrap", v, 10);

    wr(0, 0); wr(2, 1); wr(1, 5); wr(0, 1); // prescaled down
    rd(7, v); chk(v > 65535, "R2 prescale extends limit", v, 65541);
    idle(10);
    wr(0, 0); wr(2, 0);
    idle(4);
    finish_run();
  end

endmodule